// File: doc/BRIEF.md
# Paired-Register Two-Wire Slave for a 16-bit Port Expander

This block is the serial slave that sits in front of a 16-bit general-purpose port expander. It samples the two bus wires (clock and data) on a much faster system clock, finds start, repeated-start and stop conditions, and compares the first byte of each transaction with a 7-bit address taken from strap inputs. When the address matches, the slave acknowledges it and takes the next byte as a command that points at one of eight byte-wide registers.

The eight registers form four pairs: input view, output latch, polarity inversion and direction. After any data byte, written or read, the pointer moves to the other byte of the same pair, so a burst of any length alternates between the low and high halves of one 16-bit port word. It never walks on into the next pair. Reads use the usual sequence: a write transaction sets the command byte, a repeated start follows, and the address is then sent with the read bit set. The slave keeps sending bytes while the master acknowledges them.

The data line is modelled as an input plus an active-high pull-down enable. The expander pins are modelled as plain 16-bit vectors.

Top module: `pexp_i2c_slave`

## Requirements
- R1: The slave acknowledges the address byte only when its upper seven bits equal `dev_addr`. Bit 0 is the direction bit, with 0 for write and 1 for read. On a mismatch the slave drives nothing and changes nothing until the next start condition.
- R2: A command byte from 0x00 to 0x07 is acknowledged and loads the register pointer. A command byte above 0x07 is not acknowledged.
- R3: The register numbers are assigned as follows. 0 and 1 are the input view, 2 and 3 the output latch, 4 and 5 the polarity mask, and 6 and 7 the direction register. The even number is bits 7:0 of the 16-bit word and the odd number is bits 15:8. The output latch drives `port_out` and the direction register drives `port_dir`.
- R4: After each written byte is acknowledged, the pointer flips bit 0 and stays inside its pair. A single write may carry any number of data bytes.
- R5: After a repeated start with the read bit set, the slave sends the addressed register MSB first. Each master acknowledge flips the pointer and sends the other byte of the pair. A master not-acknowledge ends the read and the slave releases the data line.
- R6: Reading register 0 or 1 returns the corresponding `pin_in` byte XOR the matching polarity-mask byte.
- R7: Data bytes written to registers 0 or 1 are acknowledged and then discarded.
- R8: A stop condition may end a write at any byte boundary. Every byte already acknowledged remains in effect.
- R9: After reset, the output latch and the direction register are all ones, the polarity mask is all zeros, and the pointer is 0.
- R10: The slave changes its data-line drive only while the bus clock is low. It drives nothing after a stop condition.
- R11: A written byte reaches `port_out` or `port_dir` in the same cycle that the slave starts driving the acknowledge for that byte.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, many times faster than the bus clock |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_i | input | 1 | Bus clock wire as seen at the pin |
| sda_i | input | 1 | Bus data wire as seen at the pin |
| sda_oe | output | 1 | 1 pulls the data wire low, 0 releases it |
| dev_addr | input | 7 | Strapped 7-bit slave address |
| pin_in | input | 16 | Current level of the expander pins |
| port_out | output | 16 | Output latch word |
| port_dir | output | 16 | Direction word, 1 means the pin is an input |

## Verification
The main function is exercised by a set of write-then-read-back vectors. Each vector starts from a different pointer: low half, high half, the read-only pair and the polarity pair. Starting on the odd member shows whether the pointer flips or counts upward, and reading the input pair after loading a non-zero polarity mask separates the XOR view from a raw pin view. Directed sequences add a four-byte burst, a stop after a single byte, a wrong address, an out-of-range command and a three-byte read that ends in a not-acknowledge. Each of these separates keeping data from dropping it, and wrapping within a pair from running on past it.

// File: rtl/pexp_pkg.sv
// Shared constants and types for the paired-register serial slave.
// Assumes 8-bit registers and eight of them (four pairs of two).
package pexp_pkg;
    localparam int BYTE_W    = 8;
    localparam int REG_COUNT = 8;
    localparam int PTR_W     = $clog2(REG_COUNT);
    localparam int ADDR_W    = BYTE_W - 1;
    localparam int CNT_W     = $clog2(BYTE_W + 1);
    localparam int PORT_W    = 2 * BYTE_W;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_CMD,
        ST_WR,
        ST_RD,
        ST_MACK
    } bus_state_t;
endpackage

// File: rtl/pexp_bus_cond.sv
// Synchronises the bus clock and data wires to the system clock and
// reports clock edges plus start and stop conditions as single-cycle pulses.
// Assumes the system clock is at least ~10x the bus clock rate.
module pexp_bus_cond #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);
    logic [SYNC_STAGES:0] scl_pipe;
    logic [SYNC_STAGES:0] sda_pipe;
    logic scl_s, scl_p, sda_p;

    // Shift both wires through the synchroniser plus one history stage.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_pipe <= '1;
            sda_pipe <= '1;
        end else begin
            scl_pipe <= {scl_pipe[SYNC_STAGES-1:0], scl_i};
            sda_pipe <= {sda_pipe[SYNC_STAGES-1:0], sda_i};
        end
    end

    assign scl_s = scl_pipe[SYNC_STAGES-1];
    assign scl_p = scl_pipe[SYNC_STAGES];
    assign sda_s = sda_pipe[SYNC_STAGES-1];
    assign sda_p = sda_pipe[SYNC_STAGES];

    assign scl_rise  = scl_s & ~scl_p;
    assign scl_fall  = ~scl_s & scl_p;
    assign start_det = scl_s & scl_p & sda_p & ~sda_s;
    assign stop_det  = scl_s & scl_p & ~sda_p & sda_s;
endmodule

// File: rtl/pexp_regfile.sv
// Holds the three writable register pairs and the register pointer, and
// presents the byte the pointer selects. The input pair is a live view
// of the pins XOR the polarity mask, and writes to it are dropped.
module pexp_regfile
    import pexp_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ptr_load,
    input  logic [PTR_W-1:0]  ptr_new,
    input  logic              ptr_flip,
    input  logic              wr_en,
    input  logic [BYTE_W-1:0] wr_data,
    input  logic [PORT_W-1:0] pin_in,
    output logic [BYTE_W-1:0] rd_data,
    output logic [PORT_W-1:0] port_out,
    output logic [PORT_W-1:0] port_dir
);
    logic [1:0][BYTE_W-1:0] out_q, pol_q, cfg_q, in_view;
    logic [PTR_W-1:0]       ptr;

    // Pointer: loaded by a command byte, flipped within its pair per byte.
    always_ff @(posedge clk) begin
        if (!rst_n)        ptr <= '0;
        else if (ptr_load) ptr <= ptr_new;
        else if (ptr_flip) ptr[0] <= ~ptr[0];
    end

    // Writable pairs: update the member under the pointer on a write strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_q <= '1;
            pol_q <= '0;
            cfg_q <= '1;
        end else if (wr_en) begin
            case (ptr[PTR_W-1:1])
                2'd1:    out_q[ptr[0]] <= wr_data;
                2'd2:    pol_q[ptr[0]] <= wr_data;
                2'd3:    cfg_q[ptr[0]] <= wr_data;
                default: ;
            endcase
        end
    end

    assign in_view = pin_in ^ pol_q;

    // Read mux: pick the pair, then the member.
    always_comb begin
        case (ptr[PTR_W-1:1])
            2'd0:    rd_data = in_view[ptr[0]];
            2'd1:    rd_data = out_q[ptr[0]];
            2'd2:    rd_data = pol_q[ptr[0]];
            default: rd_data = cfg_q[ptr[0]];
        endcase
    end

    assign port_out = out_q;
    assign port_dir = cfg_q;
endmodule

// File: rtl/pexp_i2c_slave.sv
// Top of the paired-register serial slave. It runs the byte-level
// protocol: address match, command capture, write bursts and read bursts.
// Acknowledges and read data are driven through an open-drain enable.
// Assumes the bus clock is slow compared with clk.
module pexp_i2c_slave
    import pexp_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_i,
    input  logic              sda_i,
    output logic              sda_oe,
    input  logic [ADDR_W-1:0] dev_addr,
    input  logic [PORT_W-1:0] pin_in,
    output logic [PORT_W-1:0] port_out,
    output logic [PORT_W-1:0] port_dir
);
    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W);

    logic              sda_s, scl_rise, scl_fall, start_det, stop_det;
    bus_state_t        state;
    logic [CNT_W-1:0]  bit_cnt;
    logic [BYTE_W-1:0] rx_sh;
    logic [BYTE_W-2:0] tx_sh;
    logic              in_ack, rw_q, m_nack, sda_oe_q;
    logic              byte_ok, byte_end, wr_en, ptr_load, ptr_flip;
    logic [BYTE_W-1:0] rd_data;

    pexp_bus_cond #(.SYNC_STAGES(SYNC_STAGES)) u_cond (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
        .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
        .start_det(start_det), .stop_det(stop_det)
    );

    pexp_regfile u_regs (
        .clk(clk), .rst_n(rst_n),
        .ptr_load(ptr_load), .ptr_new(rx_sh[PTR_W-1:0]), .ptr_flip(ptr_flip),
        .wr_en(wr_en), .wr_data(rx_sh), .pin_in(pin_in),
        .rd_data(rd_data), .port_out(port_out), .port_dir(port_dir)
    );

    // Decide whether the byte just received earns an acknowledge.
    always_comb begin
        case (state)
            ST_ADDR: byte_ok = (rx_sh[BYTE_W-1:1] == dev_addr);
            ST_CMD:  byte_ok = (rx_sh[BYTE_W-1:PTR_W] == '0);
            default: byte_ok = 1'b1;
        endcase
    end

    assign byte_end = scl_fall && !in_ack && (bit_cnt == LAST_BIT);
    assign wr_en    = byte_end && (state == ST_WR);
    assign ptr_load = byte_end && (state == ST_CMD) && byte_ok;
    assign ptr_flip = wr_en || ((state == ST_MACK) && scl_rise);

    // Protocol sequencer: bit counting, acknowledge and transmit timing.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            bit_cnt  <= '0;
            rx_sh    <= '0;
            tx_sh    <= '0;
            in_ack   <= 1'b0;
            rw_q     <= 1'b0;
            m_nack   <= 1'b0;
            sda_oe_q <= 1'b0;
        end else if (start_det) begin
            state    <= ST_ADDR;
            bit_cnt  <= '0;
            in_ack   <= 1'b0;
            sda_oe_q <= 1'b0;
        end else if (stop_det) begin
            state    <= ST_IDLE;
            in_ack   <= 1'b0;
            sda_oe_q <= 1'b0;
        end else begin
            case (state)
                ST_ADDR, ST_CMD, ST_WR: begin
                    if (scl_rise && !in_ack && bit_cnt < LAST_BIT) begin
                        rx_sh   <= {rx_sh[BYTE_W-2:0], sda_s};
                        bit_cnt <= bit_cnt + 1'b1;
                    end else if (scl_fall && in_ack) begin
                        in_ack   <= 1'b0;
                        sda_oe_q <= 1'b0;
                        bit_cnt  <= '0;
                        if (state == ST_ADDR && rw_q) begin
                            state    <= ST_RD;
                            tx_sh    <= rd_data[BYTE_W-2:0];
                            sda_oe_q <= ~rd_data[BYTE_W-1];
                        end else if (state == ST_ADDR) begin
                            state <= ST_CMD;
                        end else begin
                            state <= ST_WR;
                        end
                    end else if (byte_end) begin
                        if (byte_ok) begin
                            in_ack   <= 1'b1;
                            sda_oe_q <= 1'b1;
                            if (state == ST_ADDR) rw_q <= rx_sh[0];
                        end else begin
                            state <= ST_IDLE;
                        end
                    end
                end
                ST_RD: begin
                    if (scl_rise) begin
                        bit_cnt <= bit_cnt + 1'b1;
                    end else if (scl_fall && bit_cnt == LAST_BIT) begin
                        sda_oe_q <= 1'b0;
                        bit_cnt  <= '0;
                        state    <= ST_MACK;
                    end else if (scl_fall && bit_cnt != '0) begin
                        sda_oe_q <= ~tx_sh[BYTE_W-2];
                        tx_sh    <= {tx_sh[BYTE_W-3:0], 1'b0};
                    end
                end
                ST_MACK: begin
                    if (scl_rise) begin
                        m_nack  <= sda_s;
                        bit_cnt <= CNT_W'(1);
                    end else if (scl_fall && bit_cnt != '0) begin
                        bit_cnt <= '0;
                        if (m_nack) begin
                            state <= ST_IDLE;
                        end else begin
                            state    <= ST_RD;
                            tx_sh    <= rd_data[BYTE_W-2:0];
                            sda_oe_q <= ~rd_data[BYTE_W-1];
                        end
                    end
                end
                default: ;
            endcase
        end
    end

    assign sda_oe = sda_oe_q;
endmodule

// File: rtl/pexp_i2c_slave_chk.sv
// Protocol and timing checks for pexp_i2c_slave, attached by bind.
// Assumes the bus clock stays low for several system clocks after each fall.
module pexp_i2c_slave_chk
    import pexp_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              scl_i,
    input logic              sda_oe,
    input logic              stop_det,
    input logic [PORT_W-1:0] port_out,
    input logic [PORT_W-1:0] port_dir
);
    // R9: the reset values are present in the first cycle after reset.
    assert_reset_values_R9: assert property (@(posedge clk)
        (rst_n && $past(!rst_n)) |-> (port_out == '1 && port_dir == '1));

    // R10: the data drive changes only while the bus clock is low.
    assert_sda_moves_low_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (sda_oe != $past(sda_oe)) |-> !scl_i);

    // R10: nothing is driven in the cycle after a stop.
    assert_release_on_stop_R10: assert property (@(posedge clk) disable iff (!rst_n)
        stop_det |=> !sda_oe);

    // R11: the output latch changes only together with an acknowledge drive.
    assert_out_on_ack_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (port_out != $past(port_out)) |-> sda_oe);

    // R11: the direction word changes only together with an acknowledge drive.
    assert_dir_on_ack_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (port_dir != $past(port_dir)) |-> sda_oe);
endmodule

bind pexp_i2c_slave pexp_i2c_slave_chk u_chk (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_oe(sda_oe),
    .stop_det(stop_det), .port_out(port_out), .port_dir(port_dir)
);

// File: tb/test_pexp_i2c_slave.sv
module test_pexp_i2c_slave;
    localparam int CLK_PERIOD = 10;
    localparam int Q = 10;
    localparam logic [6:0] ADDR = 7'h21;
    localparam int NVEC = 6;
    // cmd, w0, w1, pin_in, expected first read byte, expected second read byte
    localparam logic [55:0] VEC [NVEC] = '{
        {8'h02, 8'hA5, 8'h3C, 16'h0000, 8'hA5, 8'h3C},
        {8'h03, 8'h11, 8'h22, 16'h0000, 8'h11, 8'h22},
        {8'h07, 8'hF0, 8'h0F, 16'h0000, 8'hF0, 8'h0F},
        {8'h04, 8'h7E, 8'h81, 16'h0000, 8'h7E, 8'h81},
        {8'h00, 8'h55, 8'h66, 16'h1234, 8'h4A, 8'h93},
        {8'h01, 8'h00, 8'h00, 16'hABCD, 8'h2A, 8'hB3}
    };

    logic clk = 1'b0, rst_n = 1'b0, scl_m = 1'b1, sda_m = 1'b1;
    logic sda_oe, sda_line;
    logic [15:0] pin_in = '0, port_out, port_dir;
    int n_chk = 0, n_fail = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;
    assign sda_line = sda_m & ~sda_oe;

    pexp_i2c_slave i_pexp_i2c_slave (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line),
        .sda_oe(sda_oe), .dev_addr(ADDR), .pin_in(pin_in),
        .port_out(port_out), .port_dir(port_dir)
    );

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic bus_start;
        sda_m = 1'b1; tick(Q); scl_m = 1'b1; tick(Q);
        sda_m = 1'b0; tick(Q); scl_m = 1'b0; tick(Q);
    endtask

    task automatic bus_stop;
        sda_m = 1'b0; tick(Q); scl_m = 1'b1; tick(Q); sda_m = 1'b1; tick(Q);
    endtask

    task automatic wbyte(input logic [7:0] b, output logic ack);
        for (int i = 7; i >= 0; i--) begin
            sda_m = b[i]; tick(Q); scl_m = 1'b1; tick(2 * Q); scl_m = 1'b0; tick(Q);
        end
        sda_m = 1'b1; tick(Q); scl_m = 1'b1; tick(Q);
        ack = !sda_line; tick(Q); scl_m = 1'b0; tick(Q);
    endtask

    task automatic rbyte(input logic mack, output logic [7:0] b);
        sda_m = 1'b1;
        for (int i = 7; i >= 0; i--) begin
            tick(Q); scl_m = 1'b1; tick(Q); b[i] = sda_line; tick(Q); scl_m = 1'b0;
        end
        sda_m = !mack; tick(Q); scl_m = 1'b1; tick(2 * Q); scl_m = 1'b0; tick(Q);
        sda_m = 1'b1;
    endtask

    task automatic wr_regs(input logic [7:0] cmd, input logic [31:0] data,
                           input int n, output logic ok);
        logic a;
        bus_start;
        wbyte({ADDR, 1'b0}, a); ok = a;
        wbyte(cmd, a); ok &= a;
        for (int i = 0; i < n; i++) begin
            wbyte(data[8*i +: 8], a); ok &= a;
        end
        bus_stop;
    endtask

    task automatic rd_regs(input logic [7:0] cmd, input int n, output logic [31:0] got);
        logic a;
        logic [7:0] b;
        got = '0;
        bus_start;
        wbyte({ADDR, 1'b0}, a);
        wbyte(cmd, a);
        bus_start;
        wbyte({ADDR, 1'b1}, a);
        for (int i = 0; i < n; i++) begin
            rbyte(i != n - 1, b); got[8*i +: 8] = b;
        end
        bus_stop;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        logic ok, a;
        logic [31:0] got;
        logic [7:0] b;
        tick(5); rst_n = 1'b1; tick(5);

        // R9: reset state at the ports
        check("R9 port_out", 32'(port_out), 32'h0000FFFF);
        check("R9 port_dir", 32'(port_dir), 32'h0000FFFF);
        check("R9 sda_oe", 32'(sda_oe), 32'h0);

        // R9, R6: pointer 0 after reset, input view with zero polarity
        pin_in = 16'h5AC3;
        bus_start;
        wbyte({ADDR, 1'b1}, a);
        check("R1 read address ack", 32'(a), 32'h1);
        rbyte(1'b1, b); got[7:0] = b;
        rbyte(1'b0, b); got[15:8] = b;
        bus_stop;
        check("R9 pointer zero read", 32'(got[15:0]), 32'h5AC3);
        rd_regs(8'h04, 2, got);
        check("R9 polarity reset", got, 32'h0);

        // R3, R4, R6, R7: table walk, write two bytes then read them back
        for (int v = 0; v < NVEC; v++) begin
            pin_in = VEC[v][31:16];
            wr_regs(VEC[v][55:48], {16'h0, VEC[v][39:32], VEC[v][47:40]}, 2, ok);
            check("R2 R7 write acks", 32'(ok), 32'h1);
            rd_regs(VEC[v][55:48], 2, got);
            check("R3 R4 R6 readback", got, {16'h0, VEC[v][7:0], VEC[v][15:8]});
        end
        check("R3 port_out word", 32'(port_out), 32'h00001122);
        check("R3 port_dir word", 32'(port_dir), 32'h0000F00F);

        // R11, R4: each byte visible right after its ack, long burst wraps in pair
        bus_start;
        wbyte({ADDR, 1'b0}, a);
        wbyte(8'h02, a);
        wbyte(8'h99, a);
        check("R11 low byte after ack", 32'(port_out), 32'h00001199);
        wbyte(8'h77, a);
        check("R11 high byte after ack", 32'(port_out), 32'h00007799);
        wbyte(8'h01, a);
        wbyte(8'h02, a);
        bus_stop;
        check("R4 four-byte burst", 32'(port_out), 32'h00000201);

        // R8, R10: stop after a single byte keeps it; line released
        wr_regs(8'h03, 32'h5E, 1, ok);
        check("R8 single byte then stop", 32'(port_out), 32'h00005E01);
        check("R10 released after stop", 32'(sda_oe), 32'h0);

        // R2: out-of-range command not acknowledged
        bus_start;
        wbyte({ADDR, 1'b0}, a);
        wbyte(8'h08, a);
        check("R2 command 0x08 nack", 32'(a), 32'h0);
        bus_stop;

        // R1: wrong address ignored until the next start
        bus_start;
        wbyte({ADDR ^ 7'h01, 1'b0}, a);
        check("R1 wrong address nack", 32'(a), 32'h0);
        wbyte(8'h02, a);
        wbyte(8'h00, a);
        check("R1 ignored data nack", 32'(a), 32'h0);
        bus_stop;
        check("R1 no write on mismatch", 32'(port_out), 32'h00005E01);

        // R5: three-byte read alternates lo, hi, lo; line free after nack
        rd_regs(8'h06, 3, got);
        check("R5 three-byte read", got, 32'h000FF00F);
        check("R5 released after nack", 32'(sda_oe), 32'h0);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end
endmodule